// File: doc/BRIEF.md
# Power-of-Two Prescaled PWM Generator

This block produces a single pulse-width-modulated output from a counter that advances once per prescaled clock tick. A 3-bit select picks a divide ratio of 1, 2, 4 and so on up to 128. A period length sets how many ticks make up one period, and a duty value sets how many of those ticks the output stays high. Alongside the output, a one-clock strobe marks the last clock of every period, so a controller can time its duty updates to it.

The period length and the divide select are captured only at the moment the generator is enabled. To change either one, software drops the enable and raises it again. The duty value is sampled at start and again at every period boundary, so writing it at any time never cuts a period short. If the duty value is at or above the period length, the output stays high for the entire period.

Top module: `pow2_pwm`

## Requirements
- R1: With select value `s` (0..7) captured at start, the counter advances once every 2^s clocks.
- R2: The counter runs 0,1,...,P-1 and then wraps to 0, where P is the captured period length. One period therefore lasts exactly P×2^s clocks, and the first count after start is 0.
- R3: `pwm_out` is high while the count is below the active duty value. A duty of 0 keeps it low. A duty at or above P keeps it high for every clock of the period.
- R4: The 16-bit period input is clamped when captured: values below 3 become 3, and values above 32767 become 32767.
- R5: Changes to the period input or the divide select while the generator runs have no effect on the period.
- R6: The duty value is captured at start and at each wrap. A change made during a period first shows in the following period.
- R7: `period_end` is high for exactly the one clock in which the count is P-1 and the prescaler is about to tick, that is, the last clock of each period.
- R8: One clock after `run_en` is sampled low, `pwm_out` and `period_end` are low. A later start begins again at count 0 with a fresh prescaler.
- R9: While `rst_n` is low, `pwm_out` and `period_end` are low at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Level enable. A rising level starts the generator; low stops it. |
| div_sel | input | 3 | Divide select, ratio 2^div_sel, captured at start |
| top_in | input | 16 | Period length in ticks, clamped to 3..32767, captured at start |
| duty_in | input | 15 | High time in ticks, captured at start and at each wrap |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-clock strobe in the last clock of each period |

## Verification
The bench builds the block with its default widths: a 15-bit count and a 3-bit select. It sweeps divide selects 0 to 2 against short periods, and every duty value from 0 to two above the period. For each case it compares the output and the strobe on every clock against the arithmetic model, which reaches the 0% and 100% edges and the exact position of each wrap. Further cases cover the slowest divider, clamping at both ends, and a live change of period, select and duty.

// File: rtl/pow2_pwm_pkg.sv
// Package: shared constants for the power-of-two prescaled PWM.
// Assumes: count widths are set by the top-level parameters; only the
// lower period limit is fixed here.
package pow2_pwm_pkg;
    localparam int unsigned PWM_TOP_MIN = 3;
endpackage

// File: rtl/pow2_pwm_prescaler.sv
// Module: pow2_pwm_prescaler
// Produces a tick every 2^sel clocks while running. The select is captured
// when the generator starts.
// Assumes: start is a single-cycle pulse that happens with running low.
module pow2_pwm_prescaler #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             running,
    input  logic [SEL_W-1:0] sel_in,
    output logic             tick
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    // Capture the divide select at start.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (start) sel_q <= sel_in;
    end

    // Free-running divider count, cleared whenever the generator is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) pcnt <= '0;
        else                    pcnt <= pcnt + 1'b1;
    end

    // Low-bit mask of the chosen ratio; tick when those bits are all ones.
    always_comb begin
        mask = DIV_W'((32'd1 << sel_q) - 32'd1);
        tick = running && ((pcnt & mask) == mask);
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start) |=> $stable(sel_q)) else $error("sel changed"); // R5
endmodule

// File: rtl/pow2_pwm_counter.sv
// Module: pow2_pwm_counter
// Holds the run state, the clamped period captured at start, the duty
// value captured at start and at each wrap, and the tick counter.
// Assumes: tick is low whenever running is low.
module pow2_pwm_counter #(
    parameter int unsigned TOP_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic [TOP_W:0]   top_in,
    input  logic [TOP_W-1:0] duty_in,
    output logic             start,
    output logic             running,
    output logic [TOP_W-1:0] cnt,
    output logic [TOP_W-1:0] top_q,
    output logic [TOP_W-1:0] duty_q,
    output logic             wrap
);
    import pow2_pwm_pkg::*;

    localparam logic [TOP_W:0]   TOP_MAX_W = {1'b0, {TOP_W{1'b1}}};
    localparam logic [TOP_W-1:0] TOP_MIN_T = TOP_W'(PWM_TOP_MIN);

    logic [TOP_W-1:0] top_clamped;

    // Clamp the requested period into the legal range.
    always_comb begin
        if (top_in > TOP_MAX_W)                      top_clamped = {TOP_W{1'b1}};
        else if (top_in < (TOP_W+1)'(PWM_TOP_MIN))   top_clamped = TOP_MIN_T;
        else                                         top_clamped = top_in[TOP_W-1:0];
    end

    // Start when enabled while idle; wrap on the last tick of a period.
    always_comb begin
        start = run_en && !running;
        wrap  = running && tick && (cnt == top_q - TOP_W'(1));
    end

    // Run state, count, and captured period and duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            top_q   <= TOP_MIN_T;
            duty_q  <= '0;
        end else if (!run_en) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
            top_q   <= top_clamped;
            duty_q  <= duty_in;
        end else if (wrap) begin
            cnt     <= '0;
            duty_q  <= duty_in;
        end else if (tick) begin
            cnt     <= cnt + 1'b1;
        end
    end

    AST_CNT_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < top_q)) else $error("count past top"); // R2
    AST_TOP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (top_q >= TOP_MIN_T)) else $error("top below min"); // R4
    AST_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en) |=> $stable(top_q)) else $error("top changed"); // R5
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!running && cnt == '0)) else $error("stop not clean"); // R8
    AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en && !wrap) |=> $stable(duty_q)) else $error("duty moved"); // R6
endmodule

// File: rtl/pow2_pwm_compare.sv
// Module: pow2_pwm_compare
// Drives the PWM output high while the count is below the active duty.
// Assumes: cnt stays below the captured period while running, so any
// duty at or above the period gives a constant high.
module pow2_pwm_compare #(
    parameter int unsigned TOP_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [TOP_W-1:0] cnt,
    input  logic [TOP_W-1:0] top_q,
    input  logic [TOP_W-1:0] duty_q,
    output logic             pwm_out
);
    // Compare the count with the duty, gated by the run state.
    always_comb begin
        pwm_out = running && (cnt < duty_q);
    end

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_q >= top_q) |-> pwm_out) else $error("not full"); // R3
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_out) else $error("not zero"); // R3
endmodule

// File: rtl/pow2_pwm.sv
// Module: pow2_pwm (top)
// Single-channel PWM: power-of-two prescaler, a tick counter with a
// period captured at start, and a duty compare.
// Assumes: clk is the only clock, rst_n is synchronous and active low.
module pow2_pwm #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned TOP_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [TOP_W:0]   top_in,
    input  logic [TOP_W-1:0] duty_in,
    output logic             pwm_out,
    output logic             period_end
);
    logic             start;
    logic             running;
    logic             tick;
    logic [TOP_W-1:0] cnt;
    logic [TOP_W-1:0] top_q;
    logic [TOP_W-1:0] duty_q;

    pow2_pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .start(start), .running(running),
        .sel_in(div_sel), .tick(tick)
    );

    pow2_pwm_counter #(.TOP_W(TOP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .top_in(top_in), .duty_in(duty_in), .start(start),
        .running(running), .cnt(cnt), .top_q(top_q), .duty_q(duty_q),
        .wrap(period_end)
    );

    pow2_pwm_compare #(.TOP_W(TOP_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .running(running), .cnt(cnt),
        .top_q(top_q), .duty_q(duty_q), .pwm_out(pwm_out)
    );

    AST_PE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !start) |=> !period_end || !running) else $error("strobe long"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pwm_out && !period_end)) else $error("idle active"); // R8
endmodule

// File: tb/pow2_pwm_tb_top.sv
module pow2_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [2:0]  div_sel = '0;
    logic [15:0] top_in = 16'd3;
    logic [14:0] duty_in = '0;
    logic        pwm_out;
    logic        period_end;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pow2_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel),
        .top_in(top_in), .duty_in(duty_in), .pwm_out(pwm_out),
        .period_end(period_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One run: start, optionally change inputs during period 0, check every
    // clock against the model, then stop and check the idle outputs.
    task automatic run_case(input int sel, input int tin, input int duty,
                            input int nper, input bit alt, input int duty2,
                            input int tin2, input int sel2);
        int p_eff, div, d;
        p_eff = (tin < 3) ? 3 : ((tin > 32767) ? 32767 : tin);
        div = 1 << sel;
        @(negedge clk);
        div_sel = 3'(sel); top_in = 16'(tin); duty_in = 15'(duty); run_en = 1'b1;
        @(posedge clk);
        for (int k = 0; k < p_eff * div * nper; k++) begin
            int c, p;
            @(negedge clk);
            c = (k / div) % p_eff;
            p = (k / div) / p_eff;
            d = (alt && p > 0) ? duty2 : duty;
            // R1 R2 R3 R6: the output follows the modelled count and duty
            chk(pwm_out == (c < d), "R3", int'(pwm_out), int'(c < d));
            // R7 R1: strobe only in the final clock of a period
            chk(period_end == ((k % div == div - 1) && (c == p_eff - 1)), "R7",
                int'(period_end), int'((k % div == div - 1) && (c == p_eff - 1)));
            if (alt && k == 0) begin
                duty_in = 15'(duty2); top_in = 16'(tin2); div_sel = 3'(sel2);
            end
        end
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R8", int'(pwm_out), 0);
        chk(period_end == 1'b0, "R8", int'(period_end), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R9", int'(pwm_out), 0);
        chk(period_end == 1'b0, "R9", int'(period_end), 0);
        rst_n = 1'b1;
        // R1 R2 R3: sweep selects, short periods and every duty edge
        for (int s = 0; s < 3; s++)
            for (int t = 3; t <= 5; t++)
                for (int d = 0; d <= t + 2; d++)
                    run_case(s, t, d, 2, 1'b0, 0, 0, 0);
        // R1: slowest divider
        run_case(7, 3, 2, 2, 1'b0, 0, 0, 0);
        // R4: low clamp
        run_case(0, 0, 2, 2, 1'b0, 0, 0, 0);
        run_case(1, 2, 1, 2, 1'b0, 0, 0, 0);
        // R4: high clamp, period of 32767 clocks
        run_case(0, 16'hFFFF, 1, 1, 1'b0, 0, 0, 0);
        // R5 R6: live change of period, select and duty
        run_case(0, 4, 1, 3, 1'b1, 3, 9, 2);
        run_case(1, 6, 5, 3, 1'b1, 0, 3, 0);
        // R8: restart after stop begins at count 0 again
        run_case(2, 3, 1, 2, 1'b0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule